// File: doc/BRIEF.md
# Single-Channel Byte DMA Engine

This block moves a block of bytes between system memory and one I/O device. The processor does not touch each byte. Software loads a start address, a byte count and a device number. It then writes a control word that selects the direction and the interrupt enable, and that write starts the transfer. The engine then takes the system bus, ahead of the processor, for each byte. Every byte costs two separate bus transactions: one in memory space at the current address and one in I/O space at the device number. After the second transaction the address steps up by one and the count steps down by one.

The engine raises its bus request and keeps it raised until the external arbiter grants the bus. It finishes each access in a granted cycle. After the second access of every byte it drops the request for at least one cycle, so the processor can win the bus between stolen cycles. When the count reaches zero the engine sets a sticky done flag. If interrupts were enabled at start, it also raises an interrupt.

Top module: `dma_byte_engine`

## Requirements
- R1: After reset, busy, done, irq and busReq are all low.
- R2: Register select 0 loads the memory address, 1 loads the byte count, and 2 loads the device number. Select 3 is the control word: bit 0 = 1 for memory to device and 0 for device to memory; bit 1 enables the interrupt. Writing select 3 while idle starts a transfer.
- R3: In memory-to-device mode each byte is first a memory read (busIo=0, busWr=0) at the current address. It is then an I/O write (busIo=1, busWr=1) to the device number carrying the byte just read.
- R4: In device-to-memory mode each byte is first an I/O read (busIo=1, busWr=0) from the device number. It is then a memory write (busIo=0, busWr=1) of that byte at the current address.
- R5: After both accesses of a byte the address rises by 1 and the count falls by 1. Exactly `count` bytes move, at consecutive addresses.
- R6: An access completes only in a cycle where busReq and busGrant are both high. While busReq is held without a grant, the bus address, busIo and busWr stay unchanged.
- R7: busReq is low for at least one cycle after the second access of every byte, so each byte raises the request afresh.
- R8: At the end of a transfer done is set and held and busy falls. irq equals done while the enable bit was set at start. A new start clears done and irq.
- R9: A start with a count of zero makes no bus transaction and sets done on the next cycle.
- R10: Register writes of any select while busy are ignored. They change neither the transfer in flight nor its addresses, device, count or mode.
- R11: I/O-space accesses put the device number, zero-extended, on busAddr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select (0 address, 1 count, 2 device, 3 control/start) |
| regWrData | input | REG_W | Register write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Sticky completion flag |
| irq | output | 1 | Completion interrupt |
| busReq | output | 1 | Bus request to arbiter |
| busGrant | input | 1 | Bus grant from arbiter |
| busAddr | output | ADDR_W | Memory address or zero-extended device number |
| busIo | output | 1 | 1 = I/O-space access, 0 = memory access |
| busWr | output | 1 | 1 = write, 0 = read |
| busWData | output | 8 | Write data |
| busRData | input | 8 | Read data, sampled at the granted edge |

## Verification
The bench sweeps byte counts from zero to six in both directions. It runs each sweep under three grant patterns: always granted, every other cycle denied, and pseudo-random denial. Each granted access is logged and compared against an arithmetic model of address, device, data and order. A design that swapped the access order, dropped or repeated a byte, or advanced the address on the wrong access would show up in that log. So would a design that lost read data while waiting for a grant. The count-zero start catches an engine that issues a stray access before testing the count. A second start, plus register writes while busy, catches an engine whose done flag does not clear, or whose registers can be overwritten mid-transfer. Counting rising edges of the request catches an engine that holds the bus across bytes.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2,
    ST_GAP    = 2'd3
  } dmaState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic acceptWr;     // register file may be written
    logic capture;      // latch read data of the first access
    logic advance;      // byte finished: step address and count
    logic phaseSecond;  // bus phase selector
  } dmaStrobe_t;

  localparam logic [1:0] SEL_ADDR  = 2'd0;
  localparam logic [1:0] SEL_COUNT = 2'd1;
  localparam logic [1:0] SEL_DEV   = 2'd2;
  localparam logic [1:0] SEL_CTRL  = 2'd3;

endpackage

// File: rtl/dma_datapath.sv
module dma_datapath
  import dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DEV_W  = 8,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmaStrobe_t        stb,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic [REG_W-1:0]  regWrData,
  input  logic [7:0]        busRData,
  output logic              cntZero,
  output logic              irqEn,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busIo,
  output logic              busWr,
  output logic [7:0]        busWData
);

  localparam int PAD_W = ADDR_W - DEV_W;

  logic [ADDR_W-1:0] addrQ;
  logic [CNT_W-1:0]  cntQ;
  logic [DEV_W-1:0]  devQ;
  logic              toDevQ;
  logic              ienQ;
  logic [7:0]        holdQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      cntQ   <= '0;
      devQ   <= '0;
      toDevQ <= 1'b0;
      ienQ   <= 1'b0;
      holdQ  <= '0;
    end else begin
      if (stb.acceptWr && regWrEn) begin
        case (regSel)
          SEL_ADDR:  addrQ <= regWrData[ADDR_W-1:0];
          SEL_COUNT: cntQ  <= regWrData[CNT_W-1:0];
          SEL_DEV:   devQ  <= regWrData[DEV_W-1:0];
          default: begin
            toDevQ <= regWrData[0];
            ienQ   <= regWrData[1];
          end
        endcase
      end
      if (stb.capture) holdQ <= busRData;
      if (stb.advance) begin
        addrQ <= addrQ + 1'b1;
        cntQ  <= cntQ - 1'b1;
      end
    end
  end

  // memory-to-device: mem read, then io write; device-to-memory: io read, then mem write
  assign busIo    = ~(toDevQ ^ stb.phaseSecond);
  assign busWr    = stb.phaseSecond;
  assign busAddr  = busIo ? {{PAD_W{1'b0}}, devQ} : addrQ;
  assign busWData = holdQ;
  assign cntZero  = (cntQ == '0);
  assign irqEn    = ienQ;

  // R5
  step_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.advance |=> (cntQ == $past(cntQ) - 1'b1) && (addrQ == $past(addrQ) + 1'b1));

  // R10
  frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.acceptWr && !stb.advance) |=> $stable(addrQ) && $stable(cntQ) && $stable(devQ) && $stable(toDevQ));

endmodule

// File: rtl/dma_control.sv
module dma_control
  import dma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [1:0] regSel,
  input  logic       busGrant,
  input  logic       cntZero,
  output dmaStrobe_t stb,
  output logic       busReq,
  output logic       busy,
  output logic       done
);

  dmaState_e stateQ, stateD;
  logic      doneQ, doneD;
  logic      startWr;

  assign startWr = regWrEn && (regSel == SEL_CTRL) && (stateQ == ST_IDLE);

  always_comb begin
    stateD = stateQ;
    doneD  = doneQ;
    case (stateQ)
      ST_IDLE: if (startWr) begin
        doneD = cntZero;
        if (!cntZero) stateD = ST_FIRST;
      end
      ST_FIRST:  if (busGrant) stateD = ST_SECOND;
      ST_SECOND: if (busGrant) stateD = ST_GAP;
      default: begin
        if (cntZero) begin
          stateD = ST_IDLE;
          doneD  = 1'b1;
        end else begin
          stateD = ST_FIRST;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      doneQ  <= doneD;
    end
  end

  assign stb.acceptWr    = (stateQ == ST_IDLE);
  assign stb.capture     = (stateQ == ST_FIRST) && busGrant;
  assign stb.advance     = (stateQ == ST_SECOND) && busGrant;
  assign stb.phaseSecond = (stateQ == ST_SECOND);
  assign busReq = (stateQ == ST_FIRST) || (stateQ == ST_SECOND);
  assign busy   = (stateQ != ST_IDLE);
  assign done   = doneQ;

  // R7
  release_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.advance |=> !busReq);

  // R9
  zero_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startWr && cntZero) |=> done && !busReq && !busy);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busReq && !busy);

endmodule

// File: rtl/dma_byte_engine.sv
module dma_byte_engine
  import dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DEV_W  = 8,
  parameter int REG_W  = (ADDR_W > CNT_W) ? ADDR_W : CNT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic [REG_W-1:0]  regWrData,
  output logic              busy,
  output logic              done,
  output logic              irq,
  output logic              busReq,
  input  logic              busGrant,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busIo,
  output logic              busWr,
  output logic [7:0]        busWData,
  input  logic [7:0]        busRData
);

  dmaStrobe_t stb;
  logic       cntZero;
  logic       irqEn;

  dma_control u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .busGrant(busGrant), .cntZero(cntZero), .stb(stb),
    .busReq(busReq), .busy(busy), .done(done)
  );

  dma_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEV_W(DEV_W), .REG_W(REG_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .busRData(busRData), .cntZero(cntZero), .irqEn(irqEn),
    .busAddr(busAddr), .busIo(busIo), .busWr(busWr), .busWData(busWData)
  );

  assign irq = done && irqEn;

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busGrant) |=> busReq && $stable(busAddr) && $stable(busIo) && $stable(busWr));

  // R8
  irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $rose(done));

endmodule

// File: tb/sim_dma_byte_engine.sv
module sim_dma_byte_engine;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic [15:0] regWrData = '0;
  logic        busy, done, irq, busReq, busGrant, busIo, busWr;
  logic [15:0] busAddr;
  logic [7:0]  busWData, busRData;
  logic        stall = 1'b0;
  int          stallMode = 0;
  logic [7:0]  lfsr = 8'h5a;

  int nVec = 0;
  int nBad = 0;
  int cyc = 0;

  logic [7:0]  mem [256];
  logic [7:0]  memSnap [256];
  logic        lgIo [1024];
  logic        lgWr [1024];
  logic [15:0] lgAddr [1024];
  logic [7:0]  lgData [1024];
  int txN = 0;
  int devRd = 0;
  int reqRises = 0;
  logic reqPrev = 1'b0;

  always #2 clk = ~clk;

  dma_byte_engine u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .busy(busy), .done(done), .irq(irq), .busReq(busReq), .busGrant(busGrant),
    .busAddr(busAddr), .busIo(busIo), .busWr(busWr), .busWData(busWData), .busRData(busRData)
  );

  function automatic logic [7:0] devVal(input logic [7:0] dev, input int n);
    return 8'(dev * 8 + n * 3 + 1);
  endfunction

  assign busGrant = busReq && !stall;
  assign busRData = busIo ? devVal(busAddr[7:0], devRd) : mem[busAddr[7:0]];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    reqPrev <= busReq;
    if (rstN && busReq && !reqPrev) reqRises <= reqRises + 1;
    if (rstN && busReq && busGrant) begin
      lgIo[txN % 1024]   <= busIo;
      lgWr[txN % 1024]   <= busWr;
      lgAddr[txN % 1024] <= busAddr;
      lgData[txN % 1024] <= busWr ? busWData : busRData;
      txN <= txN + 1;
      if (busWr && !busIo) mem[busAddr[7:0]] <= busWData;
      if (busIo && !busWr) devRd <= devRd + 1;
    end
  end

  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (stallMode)
      0: stall <= 1'b0;
      1: stall <= ~stall;
      default: stall <= lfsr[0];
    endcase
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [15:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic runXfer(input bit toDev, input bit ien, input int addr, input int cnt,
                         input int dev, input int mode, input bit midWrites);
    int baseTx, baseDev, baseRise, waitCyc;
    stallMode = mode;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 5 + 1 + cnt);
    for (int i = 0; i < 256; i++) memSnap[i] = mem[i];
    regWrite(2'd0, 16'(addr));
    regWrite(2'd1, 16'(cnt));
    regWrite(2'd2, 16'(dev));
    baseTx = txN; baseDev = devRd; baseRise = reqRises;
    regWrite(2'd3, {14'd0, ien, toDev});
    // R9 / R8: done reflects only a zero-count start right after the start edge
    check(cnt == 0 ? "R9 done at once" : "R8 done cleared", {31'd0, done}, (cnt == 0) ? 1 : 0);
    if (midWrites && cnt > 0) begin
      // R10: all of these must be ignored
      regWrite(2'd0, 16'(addr + 50));
      regWrite(2'd1, 16'(cnt + 3));
      regWrite(2'd2, 16'(dev + 1));
      regWrite(2'd3, {14'd0, ~ien, ~toDev});
    end
    waitCyc = 0;
    while (!done && waitCyc < 3000) begin
      @(negedge clk);
      waitCyc++;
    end
    check("R8 done set", {31'd0, done}, 1);
    check("R8 busy low", {31'd0, busy}, 0);
    check("R8 irq", {31'd0, irq}, {31'd0, ien});
    check(cnt == 0 ? "R9 no access" : "R5 access count", txN - baseTx, 2 * cnt);
    check("R7 request per byte", reqRises - baseRise, cnt);
    for (int k = 0; k < cnt && k < 16; k++) begin
      int i0, i1;
      logic [7:0] b;
      i0 = (baseTx + 2 * k) % 1024;
      i1 = (baseTx + 2 * k + 1) % 1024;
      if (toDev) begin
        b = memSnap[(addr + k) % 256];
        // R3, R5
        check("R3 first mem read", {lgIo[i0], lgWr[i0], lgAddr[i0], lgData[i0]}, {2'b00, 16'(addr + k), b});
        // R3, R11
        check("R3 then io write", {lgIo[i1], lgWr[i1], lgAddr[i1], lgData[i1]}, {2'b11, 16'(dev), b});
      end else begin
        b = devVal(8'(dev), baseDev + k);
        // R4, R11
        check("R4 first io read", {lgIo[i0], lgWr[i0], lgAddr[i0], lgData[i0]}, {2'b10, 16'(dev), b});
        // R4, R5
        check("R4 then mem write", {lgIo[i1], lgWr[i1], lgAddr[i1], lgData[i1]}, {2'b01, 16'(addr + k), b});
        check("R4 memory content", {24'd0, mem[(addr + k) % 256]}, {24'd0, b});
      end
    end
    if (!toDev) check("R5 no write past end", {24'd0, mem[(addr + cnt) % 256]}, {24'd0, memSnap[(addr + cnt) % 256]});
    repeat (3) @(negedge clk);
    check("R8 done sticky", {31'd0, done}, 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1
    check("R1 reset busy", {31'd0, busy}, 0);
    check("R1 reset done", {31'd0, done}, 0);
    check("R1 reset irq", {31'd0, irq}, 0);
    check("R1 reset busReq", {31'd0, busReq}, 0);
    rstN = 1'b1;
    // R2: control word bit0 selects direction, bit1 enables interrupt
    for (int d = 0; d < 2; d++)
      for (int m = 0; m < 3; m++)
        for (int c = 0; c <= 6; c++)
          runXfer(d[0], c[0], 8 + c * 30 + m, c, 3 + c + m * 10, m, 1'b0);
    // R10: register writes while busy
    runXfer(1'b1, 1'b1, 40, 4, 9, 2, 1'b1);
    runXfer(1'b0, 1'b0, 90, 5, 12, 1, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    nBad++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule